// File: doc/BRIEF.md
# Stream Burst Legality Checker

This block watches the write port of a transmit FIFO. The port is a stream with a 16-byte beat. The downstream packet interface moves data in credits of a fixed byte size. A burst may stop in the middle of a packet only on a credit boundary. Every beat that does not close a packet must carry all of its bytes. The beat that closes a packet may be short, but its bytes must fill the lanes from lane 0 upward with no gaps.

The checker acts on a beat only when `s_valid` and `s_ready` are both high. It never drives the stream. For each accepted beat that breaks a rule, it raises `pat_err` for one clock in the following cycle. A separate `s_eob` input marks the end of a burst that does not end the packet. A byte counter, taken modulo the credit size, restarts at every burst end and at every packet end. The beat width and the credit size are both parameters; the credit size must be a power of two of at least 2.

Top module: `sbc_burst_checker`

## Requirements
- R1: After a synchronous reset, `pat_err` is low and the burst byte count is zero. A burst that closes after exactly one credit's worth of full beats then raises no error.
- R2: An accepted beat with `s_last`=0 that has any `s_keep` bit at 0 (that is, `s_keep` is not all ones) is illegal.
- R3: An accepted beat with `s_last`=1 must have a nonzero `s_keep` whose set bits run without gaps from bit 0. Examples are 16'h0001, 16'h0007 and 16'hFFFF. Any other value, such as 16'h0000, 16'h0006 or 16'h00F1, is illegal.
- R4: An accepted beat with `s_eob`=1 and `s_last`=0 is illegal when the burst's byte total, counting this beat, is not a multiple of CREDIT_BYTES.
- R5: A beat adds its number of set `s_keep` bits to the burst byte total. The total restarts at zero after any accepted beat with `s_eob`=1 or `s_last`=1.
- R6: A beat that is not accepted is never evaluated and never raises the error. This covers `s_valid`=1 with `s_ready`=0, and `s_ready`=1 with `s_valid`=0.
- R7: `pat_err` is high for exactly the one cycle after an illegal accepted beat. A beat that breaks several rules still gives a single one-cycle pulse.
- R8: When `s_eob` and `s_last` are both 1 on a beat, the R3 rule applies and the credit alignment of R4 is not checked.
- R9: A legal stream gives no error. A legal stream here means full non-last beats, burst ends on credit multiples, and last beats with gap-free keep from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FIFO write-side clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Beat valid on the write port |
| s_ready | input | 1 | FIFO ready on the write port |
| s_keep | input | BEAT_BYTES | Byte enables, bit i for byte lane i |
| s_last | input | 1 | Beat closes the packet |
| s_eob | input | 1 | Beat closes the burst without closing the packet |
| pat_err | output | 1 | One-cycle pulse per illegal accepted beat |

## Verification
The checks use three kinds of beat. Full and partial non-last beats separate the keep-completeness rule from the alignment rule. Last beats with gap-free, gapped and empty keep test the tail-shape decode. Handshake-off beats show that nothing is evaluated without acceptance. A second instance with a 32-byte credit runs burst ends after one and after two full beats. It also runs bursts that follow an earlier burst end or packet end. These show that the counter is taken modulo the credit size and that it restarts, which a 16-byte credit alone cannot show. Beats that break two rules at once, and back-to-back illegal beats, show one pulse per offending beat.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  // One flag per legality rule, evaluated on an accepted beat
  typedef struct packed {
    logic keep_hole;   // non-last beat with a missing byte
    logic bad_tail;    // last beat whose keep is empty or has gaps
    logic misalign;    // burst closed off a credit boundary
  } sbc_viol_t;

  function automatic logic any_viol(input sbc_viol_t v);
    return v.keep_hole | v.bad_tail | v.misalign;
  endfunction

endpackage

// File: rtl/sbc_keep_check.sv
module sbc_keep_check #(
  parameter int BEAT_BYTES = 16
) (
  input  logic [BEAT_BYTES-1:0] keep,
  input  logic                  last,
  output logic                  keep_hole,
  output logic                  bad_tail
);

  logic [BEAT_BYTES-1:0] step_ok;
  logic                  full;
  logic                  tail_ok;

  // A lane may be set only if the lane below it is set as well
  genvar gi;
  generate
    for (gi = 0; gi < BEAT_BYTES - 1; gi++) begin : g_step
      assign step_ok[gi] = ~keep[gi+1] | keep[gi];
    end
  endgenerate
  assign step_ok[BEAT_BYTES-1] = 1'b1;

  assign full    = &keep;
  assign tail_ok = keep[0] & (&step_ok);

  assign keep_hole = ~last & ~full;
  assign bad_tail  =  last & ~tail_ok;

endmodule

// File: rtl/sbc_burst_count.sv
module sbc_burst_count #(
  parameter int BEAT_BYTES   = 16,
  parameter int CREDIT_BYTES = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc,
  input  logic [BEAT_BYTES-1:0] keep,
  input  logic                  last,
  input  logic                  eob,
  output logic                  misalign
);

  localparam int CW = (CREDIT_BYTES > 2) ? $clog2(CREDIT_BYTES) : 1;
  localparam int PW = $clog2(BEAT_BYTES + 1);
  localparam int SW = ((CW > PW) ? CW : PW) + 1;

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pop;
  logic [SW-1:0] sum;
  logic [CW-1:0] sum_mod;

  always_comb begin
    pop = '0;
    for (int i = 0; i < BEAT_BYTES; i++) begin
      pop = pop + PW'(keep[i]);
    end
  end

  assign sum      = SW'(cnt_q) + SW'(pop);
  assign sum_mod  = sum[CW-1:0];
  assign misalign = eob & ~last & (sum_mod != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (acc) begin
      if (eob || last) cnt_q <= '0;
      else             cnt_q <= sum_mod;
    end
  end

  // R5: burst total restarts after a burst or packet end
  a_r5_count_restart: assert property (@(posedge clk) disable iff (rst)
    (acc && (eob || last)) |=> (cnt_q == '0));

  // R6: unaccepted beats leave the total untouched
  a_r6_count_hold: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(cnt_q));

endmodule

// File: rtl/sbc_burst_checker.sv
module sbc_burst_checker #(
  parameter int BEAT_BYTES   = 16,
  parameter int CREDIT_BYTES = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  s_valid,
  input  logic                  s_ready,
  input  logic [BEAT_BYTES-1:0] s_keep,
  input  logic                  s_last,
  input  logic                  s_eob,
  output logic                  pat_err
);
  import sbc_pkg::*;

  logic      acc;
  sbc_viol_t viol;

  assign acc = s_valid & s_ready;

  sbc_keep_check #(
    .BEAT_BYTES(BEAT_BYTES)
  ) u_keep (
    .keep      (s_keep),
    .last      (s_last),
    .keep_hole (viol.keep_hole),
    .bad_tail  (viol.bad_tail)
  );

  sbc_burst_count #(
    .BEAT_BYTES  (BEAT_BYTES),
    .CREDIT_BYTES(CREDIT_BYTES)
  ) u_count (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .keep     (s_keep),
    .last     (s_last),
    .eob      (s_eob),
    .misalign (viol.misalign)
  );

  always_ff @(posedge clk) begin
    if (rst) pat_err <= 1'b0;
    else     pat_err <= acc & any_viol(viol);
  end

  // R7: a pulse only ever follows an accepted beat
  a_r7_pulse_after_accept: assert property (@(posedge clk) disable iff (rst)
    pat_err |-> $past(acc));

  // R6: no beat accepted, no error next cycle
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !pat_err);

  // R2: partial non-last beat is flagged
  a_r2_partial_body: assert property (@(posedge clk) disable iff (rst)
    (acc && !s_last && !(&s_keep)) |=> pat_err);

  // R3: a full last beat is always legal
  a_r3_full_tail_ok: assert property (@(posedge clk) disable iff (rst)
    (acc && s_last && (&s_keep)) |=> !pat_err);

endmodule

// File: tb/sim_sbc_burst_checker.sv
module sim_sbc_burst_checker;

  localparam int BB = 16;
  localparam logic [BB-1:0] FULL = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          s_valid = 1'b0;
  logic          s_ready = 1'b0;
  logic [BB-1:0] s_keep = '0;
  logic          s_last = 1'b0;
  logic          s_eob = 1'b0;
  logic          err0;
  logic          err1;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  sbc_burst_checker #(.BEAT_BYTES(BB), .CREDIT_BYTES(16)) u0 (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_keep(s_keep), .s_last(s_last), .s_eob(s_eob), .pat_err(err0));

  sbc_burst_checker #(.BEAT_BYTES(BB), .CREDIT_BYTES(32)) u1 (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_keep(s_keep), .s_last(s_last), .s_eob(s_eob), .pat_err(err1));

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one beat at a falling edge; result is visible one falling edge later
  task automatic beat(input logic v, input logic r, input logic [BB-1:0] k,
                      input logic l, input logic e);
    s_valid = v; s_ready = r; s_keep = k; s_last = l; s_eob = e;
    @(negedge clk);
  endtask

  task automatic idle();
    beat(1'b0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 err0 after reset", err0, 1'b0);
    check("R1 err1 after reset", err1, 1'b0);
    beat(1, 1, FULL, 0, 0);
    beat(1, 1, FULL, 0, 1);
    check("R1 count zero, 32B burst legal on u1", err1, 1'b0);
    idle();
  endtask

  task automatic t_partial_body();
    beat(1, 1, 16'h7FFF, 0, 0);
    check("R2 partial non-last 7FFF", err0, 1'b1);
    beat(1, 1, 16'hFFFE, 0, 0);
    check("R2 partial non-last FFFE (back-to-back)", err0, 1'b1);
    idle();
    check("R7 pulse drops after idle", err0, 1'b0);
    beat(1, 1, FULL, 0, 0);
    check("R2 full non-last legal", err0, 1'b0);
    beat(1, 1, FULL, 1, 0);
    idle();
  endtask

  task automatic t_tail_shape();
    beat(1, 1, 16'h0007, 1, 0);
    check("R3 tail 0007 legal", err0, 1'b0);
    beat(1, 1, 16'h0001, 1, 0);
    check("R3 tail 0001 legal", err0, 1'b0);
    beat(1, 1, 16'h0006, 1, 0);
    check("R3 tail 0006 gap at bit0", err0, 1'b1);
    beat(1, 1, 16'h00F1, 1, 0);
    check("R3 tail 00F1 gap", err0, 1'b1);
    beat(1, 1, 16'h0000, 1, 0);
    check("R3 tail empty", err0, 1'b1);
    beat(1, 1, FULL, 1, 0);
    check("R3 tail full legal", err0, 1'b0);
    idle();
  endtask

  task automatic t_align();
    beat(1, 1, FULL, 0, 1);
    check("R4 16B burst end on 16B credit", err0, 1'b0);
    check("R4 16B burst end on 32B credit", err1, 1'b1);
    beat(1, 1, FULL, 0, 0);
    beat(1, 1, FULL, 0, 1);
    check("R4 32B burst end on 32B credit", err1, 1'b0);
    idle();
  endtask

  task automatic t_restart();
    // eob restarts: 16B end (err), then 32B end must be clean
    beat(1, 1, FULL, 0, 1);
    check("R5 first end misaligned u1", err1, 1'b1);
    beat(1, 1, FULL, 0, 0);
    beat(1, 1, FULL, 0, 1);
    check("R5 restart after eob", err1, 1'b0);
    // last restarts: 16B, last, then 32B end
    beat(1, 1, FULL, 0, 0);
    beat(1, 1, FULL, 1, 0);
    beat(1, 1, FULL, 0, 0);
    beat(1, 1, FULL, 0, 1);
    check("R5 restart after last", err1, 1'b0);
    idle();
  endtask

  task automatic t_no_accept();
    beat(1, 0, 16'h0003, 0, 1);
    check("R6 valid without ready u0", err0, 1'b0);
    check("R6 valid without ready u1", err1, 1'b0);
    beat(0, 1, 16'h00F0, 1, 0);
    check("R6 ready without valid", err0, 1'b0);
    // unaccepted beats must not disturb the count
    beat(1, 1, FULL, 0, 0);
    beat(1, 0, FULL, 0, 0);
    beat(1, 1, FULL, 0, 1);
    check("R6 stalled beat not counted", err1, 1'b0);
    idle();
  endtask

  task automatic t_double();
    beat(1, 1, 16'h0FFF, 0, 1);
    check("R7 double violation pulse", err0, 1'b1);
    idle();
    check("R7 single cycle pulse", err0, 1'b0);
  endtask

  task automatic t_eob_last();
    beat(1, 1, FULL, 0, 0);
    beat(1, 1, 16'h0003, 1, 1);
    check("R8 eob+last legal tail, no alignment u0", err0, 1'b0);
    check("R8 eob+last legal tail, no alignment u1", err1, 1'b0);
    beat(1, 1, 16'h0005, 1, 1);
    check("R8 eob+last bad tail", err0, 1'b1);
    idle();
  endtask

  task automatic t_legal_stream();
    int errs = 0;
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 3; b++) begin
        beat(1, 1, FULL, 0, (b == 1) ? 1'b1 : 1'b0);
        errs += int'(err0);
      end
      beat(1, 1, BB'((1 << (p + 1)) - 1), 1, 0);
      errs += int'(err0);
    end
    idle();
    check("R9 legal stream no errors", (errs == 0), 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_partial_body();
    t_tail_shape();
    t_align();
    t_restart();
    t_no_accept();
    t_double();
    t_eob_last();
    t_legal_stream();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule